// File: doc/BRIEF.md
# SDRAM Read-Transition Command Scheduler

This block sits on the controller side of an SDRAM port whose rows are already open. It takes a stream of requests (read a run of columns, write one word, close one bank, close every bank) through a valid/ready handshake. It turns them into command-bus cycles on the chip-select, row-strobe, column-strobe and write-enable lines, plus bank, address, data mask and write data. Reads use the device's full-page burst, so every read burst runs until a later command ends it. Writes use the single-location write mode.

Issue times are worked out backwards from the clock at which the last wanted read word is valid. A read or a bank close that follows a burst is placed CAS latency minus one cycles before that edge, so the data stream stays gapless. A write that follows a burst has to wait for two things. The data mask must be raised three bus cycles ahead of the write, which hides the unwanted words still coming out of the burst. One bus cycle must also be left free between the last wanted word and the write. If no usable request is waiting when a burst reaches its last wanted column, the block closes the burst's bank by itself. A strobe marks every wanted read word as it arrives on the data pins.

Top module: `sdr_rd_sched`

## Requirements
- R1: While reset is held, the bus shows NOP (chip select low, row strobe, column strobe and write enable high), data mask low, write-data enable low and the read-valid strobe low.
- R2: A request is taken on a rising edge at which `req_valid` and `req_ready` are both high, and its command appears on the bus in the next cycle. Kind codes: 0 read, 1 write, 2 precharge one bank, 3 precharge all. Command codes as {cs_n,ras_n,cas_n,we_n}: read 0101, write 0100, precharge 0010. Reads and writes carry the column in the low address bits with address bit 10 low. Precharge-all drives address bit 10 high.
- R3: A read that follows a read of length L goes on the bus exactly L cycles after it, which is CAS latency minus one cycles before the last wanted word is valid. With L equal to 1, reads go out on consecutive cycles. The bus shows NOP during the burst's remaining columns.
- R4: The read-valid strobe is high exactly in bus cycles T+CL through T+CL+L-1 for a read on the bus in cycle T. A length of 0 counts as 1.
- R5: A precharge of the burst's own bank, or a precharge-all, waiting when a burst of length L reaches its end goes on the bus L cycles after the read.
- R6: If a burst reaches its end with no request waiting, or with a precharge of a different bank waiting, the block puts a precharge of the burst's bank on the bus L cycles after the read. A waiting request is accepted on a later cycle.
- R7: For a write that ends a read burst, the data mask is high on the three bus cycles before the write and low on the write cycle. The mask stays low during the wanted words.
- R8: A write that ends a burst of length L goes on the bus CL+L+1 cycles after the read, so that one bus cycle with no read-valid lies between the last wanted word and the write. `req_ready` stays low until then.
- R9: A write that follows a precharge which ended a burst goes on the bus no sooner than CL+1 cycles after that precharge. No data mask is raised in that case.
- R10: Write data is driven, with its output enable high, only in the write's bus cycle.
- R11: With no burst running, read and precharge requests are accepted in the cycle they are presented, even while the data pins are still draining. A write is accepted at once when nothing is draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge |
| req_kind | input | 2 | 0 read, 1 write, 2 precharge bank, 3 precharge all |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Start column (read) or column (write) |
| req_len | input | LEN_W | Wanted read words (0 means 1) |
| req_wdata | input | DATA_W | Write data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | DATA_W | Write data to pins |
| sd_dq_oe | output | 1 | Write-data output enable |
| rd_valid | output | 1 | Wanted read word on the pins this cycle |

## Verification
Every internal fault in this block shows up at the ports within a few cycles, because the whole schedule runs off a single countdown and a three-state controller. A countdown that is one cycle off moves the next read, the closing precharge or the write to the wrong bus cycle. It also opens a hole in, or overlaps, the read-valid run by the same amount. That shows within L+CL+1 cycles of the read. A wrong state after a burst shows up in one of two ways: a mask that rises a cycle late or early, or a write with no free cycle before it. Either is visible on the three cycles before the write. A burst that the block fails to close shows as a missing precharge in the cycle right after the last wanted column.

// File: rtl/sdr_rt_pkg.sv
// Shared types for the read-transition scheduler: request kinds,
// internal command ops, controller states and the pin encoding.
package sdr_rt_pkg;

    typedef enum logic [1:0] {
        K_READ   = 2'd0,
        K_WRITE  = 2'd1,
        K_PRE    = 2'd2,
        K_PREALL = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_READ,
        OP_WRITE,
        OP_PRE,
        OP_PREALL
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BURST,
        ST_WTURN
    } state_e;

    // Returns {cs_n, ras_n, cas_n, we_n} for an op (active-low truth table).
    function automatic logic [3:0] op_pins(op_e op);
        case (op)
            OP_READ:   return 4'b0101;
            OP_WRITE:  return 4'b0100;
            OP_PRE:    return 4'b0010;
            OP_PREALL: return 4'b0010;
            default:   return 4'b0111;
        endcase
    endfunction

endpackage

// File: rtl/sdr_rt_fsm.sv
// Scheduling controller. Decides, each cycle, which op (if any) goes out
// and whether the waiting request is taken. One countdown serves three
// roles: columns left in a read burst, cycles left before a write that
// ends a burst, and drain cycles left after a burst was closed.
// Assumes: full-page read bursts, single-location writes, rows already
// open, CL >= 2, requester holds a request stable until it is taken.
module sdr_rt_fsm
    import sdr_rt_pkg::*;
#(
    parameter int CL       = 3,
    parameter int BANK_W   = 2,
    parameter int LEN_W    = 4,
    parameter int DQM_LEAD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    output op_e               op,
    output logic [BANK_W-1:0] op_bank,
    output logic              dqm_next,
    output logic              col_push
);

    localparam int CL_W  = $clog2(CL + 1);
    localparam int CNT_W = (LEN_W > CL_W) ? LEN_W : CL_W;
    localparam logic [CNT_W-1:0] CNT_CL   = CNT_W'(CL);
    localparam logic [CNT_W-1:0] CNT_LEAD = CNT_W'(DQM_LEAD);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic             LEAD_AT_END = ((CL + 1) <= DQM_LEAD);

    state_e             st_q, st_n;
    logic [CNT_W-1:0]   rem_q, rem_n;
    logic [BANK_W-1:0]  bank_q, bank_n;
    logic [CNT_W-1:0]   len_m1;
    logic               k_rd, k_wr, k_pre, k_all;

    // Decode the request kind and the reload value for a read burst.
    always_comb begin
        k_rd   = req_valid && (req_kind == K_READ);
        k_wr   = req_valid && (req_kind == K_WRITE);
        k_pre  = req_valid && (req_kind == K_PRE);
        k_all  = req_valid && (req_kind == K_PREALL);
        len_m1 = (req_len == '0) ? '0 : CNT_W'(req_len - LEN_W'(1));
    end

    // Next-state, op selection and handshake for the current cycle.
    always_comb begin
        st_n      = st_q;
        rem_n     = rem_q;
        bank_n    = bank_q;
        op        = OP_NOP;
        op_bank   = req_bank;
        req_ready = 1'b0;
        dqm_next  = 1'b0;
        col_push  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                rem_n = (rem_q != '0) ? rem_q - CNT_ONE : '0;
                if (k_rd) begin
                    op        = OP_READ;
                    req_ready = 1'b1;
                    col_push  = 1'b1;
                    st_n      = ST_BURST;
                    rem_n     = len_m1;
                    bank_n    = req_bank;
                end else if (k_wr && (rem_q == '0)) begin
                    op        = OP_WRITE;
                    req_ready = 1'b1;
                end else if (k_pre) begin
                    op        = OP_PRE;
                    req_ready = 1'b1;
                end else if (k_all) begin
                    op        = OP_PREALL;
                    req_ready = 1'b1;
                end
            end
            ST_BURST: begin
                if (rem_q != '0) begin
                    rem_n    = rem_q - CNT_ONE;
                    col_push = 1'b1;
                end else if (k_rd) begin
                    op        = OP_READ;
                    req_ready = 1'b1;
                    col_push  = 1'b1;
                    rem_n     = len_m1;
                    bank_n    = req_bank;
                end else if (k_wr) begin
                    st_n     = ST_WTURN;
                    rem_n    = CNT_CL;
                    dqm_next = LEAD_AT_END;
                end else if (k_all || (k_pre && (req_bank == bank_q))) begin
                    op        = k_all ? OP_PREALL : OP_PRE;
                    req_ready = 1'b1;
                    st_n      = ST_IDLE;
                    rem_n     = CNT_CL;
                end else begin
                    op      = OP_PRE;
                    op_bank = bank_q;
                    st_n    = ST_IDLE;
                    rem_n   = CNT_CL;
                end
            end
            ST_WTURN: begin
                if (rem_q != '0) begin
                    rem_n    = rem_q - CNT_ONE;
                    dqm_next = (rem_q <= CNT_LEAD);
                end else if (k_wr) begin
                    op        = OP_WRITE;
                    req_ready = 1'b1;
                    st_n      = ST_IDLE;
                end else begin
                    op      = OP_PRE;
                    op_bank = bank_q;
                    st_n    = ST_IDLE;
                    rem_n   = CNT_CL;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State, countdown and burst-bank registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            rem_q  <= '0;
            bank_q <= '0;
        end else begin
            st_q   <= st_n;
            rem_q  <= rem_n;
            bank_q <= bank_n;
        end
    end

endmodule

// File: rtl/sdr_rt_cmd_reg.sv
// Output stage. Registers the chosen op onto the command pins together
// with bank, address, data mask and write data, so every pin changes on
// the same edge. Assumes COL_W <= AP_BIT so the column never reaches the
// auto-precharge / all-banks address bit.
module sdr_rt_cmd_reg
    import sdr_rt_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int ADDR_W = 13,
    parameter int DATA_W = 16,
    parameter int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [BANK_W-1:0] op_bank,
    input  logic [COL_W-1:0]  op_col,
    input  logic [DATA_W-1:0] op_wdata,
    input  logic              dqm_next,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              dqm,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic [ADDR_W-1:0] addr_n;

    // Address for the op: column for column commands, bit AP_BIT for all-banks.
    always_comb begin
        addr_n = '0;
        if (op == OP_READ || op == OP_WRITE) begin
            addr_n = ADDR_W'(op_col);
        end else if (op == OP_PREALL) begin
            addr_n[AP_BIT] = 1'b1;
        end
    end

    // Register every bus pin; reset leaves a NOP on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cs_n, ras_n, cas_n, we_n} <= 4'b0111;
            ba     <= '0;
            addr   <= '0;
            dqm    <= 1'b0;
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else begin
            {cs_n, ras_n, cas_n, we_n} <= op_pins(op);
            ba     <= (op == OP_NOP) ? '0 : op_bank;
            addr   <= addr_n;
            dqm    <= dqm_next;
            dq_out <= (op == OP_WRITE) ? op_wdata : '0;
            dq_oe  <= (op == OP_WRITE);
        end
    end

endmodule

// File: rtl/sdr_rt_rdv_pipe.sv
// Read-valid delay line. A one enters for every wanted column as it is
// decided and leaves DEPTH cycles later, which is one cycle of command
// register plus the CAS latency. Assumes DEPTH >= 2.
module sdr_rt_rdv_pipe #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    output logic rdv
);

    logic [DEPTH-1:0] sr_q;

    // First stage takes the push flag.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q[0] <= 1'b0;
        else        sr_q[0] <= push;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        // Each later stage copies its predecessor.
        always_ff @(posedge clk) begin
            if (!rst_n) sr_q[g] <= 1'b0;
            else        sr_q[g] <= sr_q[g-1];
        end
    end

    assign rdv = sr_q[DEPTH-1];

endmodule

// File: rtl/sdr_rd_sched.sv
// Top of the read-transition scheduler. Joins the controller, the output
// register stage and the read-valid delay line. Every command appears on
// the bus one cycle after its request is taken (R2).
// Assumes: CL is 2 or 3, banks already hold open rows.
module sdr_rd_sched #(
    parameter int CL     = 3,
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int ADDR_W = 13,
    parameter int LEN_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              sd_dqm,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    output logic              rd_valid
);

    localparam int AP_BIT    = 10;
    localparam int DQM_LEAD  = 3;
    localparam int RDV_DEPTH = CL + 1;

    sdr_rt_pkg::op_e    op;
    logic [BANK_W-1:0]  op_bank;
    logic               dqm_next;
    logic               col_push;

    sdr_rt_fsm #(
        .CL(CL), .BANK_W(BANK_W), .LEN_W(LEN_W), .DQM_LEAD(DQM_LEAD)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind),
        .req_bank(req_bank), .req_len(req_len),
        .req_ready(req_ready), .op(op), .op_bank(op_bank),
        .dqm_next(dqm_next), .col_push(col_push)
    );

    sdr_rt_cmd_reg #(
        .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .AP_BIT(AP_BIT)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .op(op), .op_bank(op_bank), .op_col(req_col),
        .op_wdata(req_wdata), .dqm_next(dqm_next),
        .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
        .ba(sd_ba), .addr(sd_addr), .dqm(sd_dqm),
        .dq_out(sd_dq_out), .dq_oe(sd_dq_oe)
    );

    sdr_rt_rdv_pipe #(
        .DEPTH(RDV_DEPTH)
    ) u_rdv (
        .clk(clk), .rst_n(rst_n), .push(col_push), .rdv(rd_valid)
    );

endmodule

// File: rtl/sdr_rd_sched_chk.sv
// Checker for the scheduler's bus rules, attached to every instance of
// the top by the bind below. Tracks whether a read burst is open from
// the bus alone.
module sdr_rd_sched_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_kind,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       a10,
    input logic       dqm,
    input logic       rd_valid
);

    logic rd_bus, wr_bus, pre_bus, open_q;

    // Classify the command now on the bus.
    always_comb begin
        rd_bus  = !cs_n &&  ras_n && !cas_n &&  we_n;
        wr_bus  = !cs_n &&  ras_n && !cas_n && !we_n;
        pre_bus = !cs_n && !ras_n &&  cas_n && !we_n;
    end

    // A read opens a burst; a write or a precharge closes it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 open_q <= 1'b0;
        else if (rd_bus)            open_q <= 1'b1;
        else if (wr_bus || pre_bus) open_q <= 1'b0;
    end

    AST_WRITE_MASK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bus |-> !dqm); // R7
    AST_WRITE_MASK_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bus && open_q) |-> ($past(dqm, 1) && $past(dqm, 2) && $past(dqm, 3))); // R7
    AST_WRITE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bus |-> !$past(rd_valid)); // R8
    AST_WANTED_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(dqm, 2)); // R4
    AST_READ_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'd0) |=> rd_bus); // R2
    AST_PREALL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'd3) |=> (pre_bus && a10)); // R2

endmodule

bind sdr_rd_sched sdr_rd_sched_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .cs_n(sd_cs_n), .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .a10(sd_addr[AP_BIT]), .dqm(sd_dqm), .rd_valid(rd_valid)
);

// File: tb/tb_sdr_rd_sched.sv
module tb_sdr_rd_sched;

    localparam int CL = 3, BW = 2, CW = 9, AW = 13, LW = 4, DW = 16;
    localparam int LOGN = 2048;
    localparam logic [3:0] C_NOP = 4'b0111, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010;

    typedef struct packed {
        logic [1:0]    kind;
        logic [BW-1:0] bank;
        logic [CW-1:0] col;
        logic [LW-1:0] len;
        logic [DW-1:0] data;
        logic [3:0]    code;
        logic          a10;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd0, 9'h003, 4'd1, 16'hA5A5, C_WR,  1'b0},
        '{2'd2, 2'd2, 9'h000, 4'd0, 16'h0000, C_PRE, 1'b0},
        '{2'd3, 2'd1, 9'h000, 4'd0, 16'h0000, C_PRE, 1'b1},
        '{2'd0, 2'd1, 9'h1FF, 4'd1, 16'h0000, C_RD,  1'b0},
        '{2'd1, 2'd3, 9'h100, 4'd1, 16'h0F0F, C_WR,  1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_kind = '0;
    logic [BW-1:0] req_bank = '0;
    logic [CW-1:0] req_col = '0;
    logic [LW-1:0] req_len = '0;
    logic [DW-1:0] req_wdata = '0;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe, rd_valid;
    logic [BW-1:0] sd_ba;
    logic [AW-1:0] sd_addr;
    logic [DW-1:0] sd_dq_out;

    sdr_rd_sched #(.CL(CL), .BANK_W(BW), .COL_W(CW), .ADDR_W(AW),
                   .LEN_W(LW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_bank(req_bank), .req_col(req_col),
        .req_len(req_len), .req_wdata(req_wdata),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .rd_valid(rd_valid)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [3:0]    lg_code [LOGN];
    logic [BW-1:0] lg_ba   [LOGN];
    logic [AW-1:0] lg_addr [LOGN];
    logic [DW-1:0] lg_dq   [LOGN];
    logic          lg_dqm  [LOGN];
    logic          lg_rdv  [LOGN];
    logic          lg_oe   [LOGN];

    // Record the bus for each cycle, sampled mid-cycle.
    always @(negedge clk) begin
        if (cyc < LOGN) begin
            lg_code[cyc] = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            lg_ba[cyc]   = sd_ba;
            lg_addr[cyc] = sd_addr;
            lg_dq[cyc]   = sd_dq_out;
            lg_dqm[cyc]  = sd_dqm;
            lg_rdv[cyc]  = rd_valid;
            lg_oe[cyc]   = sd_dq_oe;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Present a request; wait until taken. pc = cycle presented, bc = bus cycle.
    task automatic send(input logic [1:0] k, input logic [BW-1:0] b,
                        input logic [CW-1:0] c, input logic [LW-1:0] l,
                        input logic [DW-1:0] d, output int pc, output int bc);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_bank = b;
        req_col = c; req_len = l; req_wdata = d;
        pc = cyc;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        bc = cyc + 1;
        @(posedge clk);
    endtask

    task automatic drop();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        int pc, t1, t2, t3, sum;
        // Reset state (R1).
        repeat (3) @(negedge clk);
        chk("R1 bus NOP in reset", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(C_NOP));
        chk("R1 dqm low in reset", int'(sd_dqm), 0);
        chk("R1 oe low in reset", int'(sd_dq_oe), 0);
        chk("R1 rd_valid low in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        idle(4);

        // Table walk: single requests from an idle, drained scheduler (R2, R10, R11).
        for (int i = 0; i < NV; i++) begin
            idle(10);
            send(VECS[i].kind, VECS[i].bank, VECS[i].col, VECS[i].len,
                 VECS[i].data, pc, t1);
            drop();
            idle(3);
            chk("R11 taken when presented", t1, pc + 1);
            chk("R2 command code", int'(lg_code[t1]), int'(VECS[i].code));
            chk("R2 address bit 10", int'(lg_addr[t1][10]), int'(VECS[i].a10));
            if (VECS[i].kind == 2'd0 || VECS[i].kind == 2'd1)
                chk("R2 column on address", int'(lg_addr[t1]), int'(VECS[i].col));
            if (VECS[i].kind != 2'd3)
                chk("R2 bank", int'(lg_ba[t1]), int'(VECS[i].bank));
            if (VECS[i].kind == 2'd1) begin
                chk("R10 write data", int'(lg_dq[t1]), int'(VECS[i].data));
                chk("R10 oe on write", int'(lg_oe[t1]), 1);
                chk("R10 oe after write", int'(lg_oe[t1 + 1]), 0);
            end
        end

        // A: chained reads, then auto close (R3, R4, R6).
        idle(10);
        send(2'd0, 2'd1, 9'd5, 4'd4, '0, pc, t1);
        send(2'd0, 2'd1, 9'd20, 4'd2, '0, pc, t2);
        drop(); idle(12);
        chk("R3 chain distance", t2 - t1, 4);
        chk("R3 NOP mid burst", int'(lg_code[t1 + 2]), int'(C_NOP));
        chk("R2 chained column", int'(lg_addr[t2]), 20);
        chk("R4 no rdv before CL", int'(lg_rdv[t1 + CL - 1]), 0);
        sum = 0;
        for (int k = t1 + CL; k < t1 + CL + 6; k++) sum += int'(lg_rdv[k]);
        chk("R4 rdv run length", sum, 6);
        chk("R4 rdv ends", int'(lg_rdv[t1 + CL + 6]), 0);
        chk("R6 auto close code", int'(lg_code[t2 + 2]), int'(C_PRE));
        chk("R6 auto close bank", int'(lg_ba[t2 + 2]), 1);
        chk("R6 auto close single bank", int'(lg_addr[t2 + 2][10]), 0);

        // B: write ending a read burst (R7, R8, R10).
        idle(10);
        send(2'd0, 2'd2, 9'd7, 4'd3, '0, pc, t1);
        send(2'd1, 2'd2, 9'd9, 4'd0, 16'hBEEF, pc, t2);
        drop(); idle(6);
        chk("R8 write distance", t2 - t1, CL + 3 + 1);
        chk("R7 mask low on wanted", int'(lg_dqm[t1 + 3]), 0);
        sum = 0;
        for (int k = t2 - 3; k < t2; k++) sum += int'(lg_dqm[k]);
        chk("R7 mask lead cycles", sum, 3);
        chk("R7 mask low at write", int'(lg_dqm[t2]), 0);
        chk("R8 last wanted word", int'(lg_rdv[t1 + CL + 2]), 1);
        chk("R8 free cycle before write", int'(lg_rdv[t2 - 1]), 0);
        chk("R2 write code", int'(lg_code[t2]), int'(C_WR));
        chk("R10 data on write", int'(lg_dq[t2]), 16'hBEEF);
        chk("R10 oe drops", int'(lg_oe[t2 + 1]), 0);

        // C: close then write waits for drain (R5, R9).
        idle(10);
        send(2'd0, 2'd0, 9'd1, 4'd2, '0, pc, t1);
        send(2'd2, 2'd0, 9'd0, 4'd0, '0, pc, t2);
        send(2'd1, 2'd0, 9'd4, 4'd0, 16'h1234, pc, t3);
        drop(); idle(4);
        chk("R5 close distance", t2 - t1, 2);
        chk("R9 drain wait", t3 - t2, CL + 1);
        sum = 0;
        for (int k = t1; k <= t3; k++) sum += int'(lg_dqm[k]);
        chk("R9 no mask", sum, 0);

        // D: precharge-all at burst end (R5).
        idle(10);
        send(2'd0, 2'd3, 9'd0, 4'd1, '0, pc, t1);
        send(2'd3, 2'd0, 9'd0, 4'd0, '0, pc, t2);
        drop(); idle(4);
        chk("R5 close-all distance", t2 - t1, 1);
        chk("R5 close-all bit", int'(lg_addr[t2][10]), 1);

        // E: back-to-back single-word reads across banks (R3, R4, R6).
        idle(10);
        send(2'd0, 2'd0, 9'd2, 4'd1, '0, pc, t1);
        send(2'd0, 2'd1, 9'd3, 4'd1, '0, pc, t2);
        send(2'd0, 2'd2, 9'd4, 4'd1, '0, pc, t3);
        drop(); idle(8);
        chk("R3 consecutive read 2", t2 - t1, 1);
        chk("R3 consecutive read 3", t3 - t2, 1);
        sum = 0;
        for (int k = t1 + CL; k < t1 + CL + 3; k++) sum += int'(lg_rdv[k]);
        chk("R4 rdv three words", sum, 3);
        chk("R6 close last bank", int'(lg_ba[t3 + 1]), 2);

        // F: zero length counts as one (R4).
        idle(10);
        send(2'd0, 2'd1, 9'd0, 4'd0, '0, pc, t1);
        send(2'd0, 2'd1, 9'd1, 4'd1, '0, pc, t2);
        drop(); idle(8);
        chk("R4 zero length chain", t2 - t1, 1);

        // G and H: close of another bank waits; idle read is immediate (R6, R11).
        idle(10);
        send(2'd0, 2'd1, 9'd3, 4'd2, '0, pc, t1);
        send(2'd2, 2'd2, 9'd0, 4'd0, '0, pc, t2);
        send(2'd0, 2'd0, 9'd6, 4'd1, '0, pc, t3);
        drop(); idle(8);
        chk("R6 own close code", int'(lg_code[t1 + 2]), int'(C_PRE));
        chk("R6 own close bank", int'(lg_ba[t1 + 2]), 1);
        chk("R6 other close after", t2 - t1, 3);
        chk("R6 other close bank", int'(lg_ba[t2]), 2);
        chk("R11 read during drain", t3 - t2, 1);

        done = 1'b1;
        report();
        $finish;
    end

endmodule